// File: doc/BRIEF.md
# Camera Frame Capture Controller

This block is the control and status unit of one capture pipe that moves camera frames into memory. The pixel side supplies a start-of-frame pulse, a frame-end strobe and a beat strobe for each group of bytes ready to be stored. The block turns each beat into a write request with a destination address. It tracks how many bytes the current frame has used and applies an optional per-frame byte budget. It also raises frame-end, start-of-frame and overrun events toward software.

Software uses a plain 32-bit register bus. Writes take effect at the clock edge. Reads are combinational from the address. The destination base address is double-buffered: software may program the next frame's buffer at any time, and the pipe picks it up only at the following start of frame. Stopping is graceful. Clearing the capture request lets the running frame reach its end, and only later frames are skipped.

The write port is valid/ready. A beat is stored when `wr_valid` and `wr_ready` are both high in the same cycle. `wr_valid` never depends on `wr_ready`. The camera side cannot be stalled, so `pix_beat` has no ready. A beat offered while the port is not ready is lost and reported as an overrun.

Top module: `cam_frame_capture`

## Requirements
- R1: After reset every register reads 0, `irq` is 0, `wr_valid` is 0 and `wr_addr` is 0.
- R2: A write to the address register (offset 0x08) does not change `wr_addr` until the next `frm_start` pulse. On that pulse the written value becomes the frame base.
- R3: A frame is captured only if pipe enable (bit 31 of offset 0x00) and capture request (bit 3 of offset 0x04) are both 1 at its `frm_start`. If either is 0, beats in that frame raise no `wr_valid`. Capture-active (bit 23 of offset 0x14) reads 1 while a frame is being captured.
- R4: Within a captured frame, `wr_addr` equals the frame base plus the bytes accepted so far. Each accepted beat adds BEAT_BYTES (4).
- R5: If the capture request is cleared during a frame, that frame keeps writing until `frm_end`. Capture-active then drops to 0.
- R6: When the limit is enabled (offset 0x0C, bit 31 enable, bits 23:0 limit in 32-bit words), a beat that would take the frame past limit×4 bytes raises no `wr_valid`. The frame count then saturates at limit×4.
- R7: `frm_end` in a captured frame stores the frame's accepted byte count at offset 0x10 and sets the frame-end flag (bit 9 of offset 0x18).
- R8: Every `frm_start` sets the start-of-frame flag (bit 10 of offset 0x18).
- R9: A beat during capture with `wr_ready` low sets the overrun flag (bit 15 of offset 0x18). That beat is not counted and does not advance `wr_addr`.
- R10: Writing 1 to bit 9, 10 or 15 of offset 0x20 clears that flag. If an event sets a flag in the same cycle, the set wins.
- R11: `irq` is high whenever some flag is set and its enable bit, at the same position in offset 0x1C, is 1.
- R12: `frm_end` outside a captured frame sets no flag and leaves offset 0x10 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |
| frm_start | input | 1 | Start-of-frame pulse |
| frm_end | input | 1 | Frame-end strobe |
| pix_beat | input | 1 | One beat of BEAT_BYTES ready from the pixel side |
| wr_valid | output | 1 | Write request to the memory port |
| wr_ready | input | 1 | Memory port can take a write |
| wr_addr | output | 32 | Destination byte address of the beat |
| frame_bytes | output | 32 | Bytes accepted so far in the current frame |
| irq | output | 1 | Interrupt request |

## Verification
A wrong frame base or byte counter shows as a wrong `wr_addr` on the very next accepted beat. The scoreboard compares every accepted beat against the address the bench predicts, so an error is caught in the cycle it happens. A wrong capture or stop decision shows as `wr_valid` appearing, or missing, on the first beat of the affected frame. Flag, priority and limit mistakes show up in the register read taken right after the triggering event, and in `irq` in the same cycle.

// File: rtl/cfc_pkg.sv
package cfc_pkg;
  localparam int REG_AW = 6;

  localparam logic [REG_AW-1:0] OFF_PIPE   = 6'h00;
  localparam logic [REG_AW-1:0] OFF_CTRL   = 6'h04;
  localparam logic [REG_AW-1:0] OFF_BASE   = 6'h08;
  localparam logic [REG_AW-1:0] OFF_LIMIT  = 6'h0C;
  localparam logic [REG_AW-1:0] OFF_COUNT  = 6'h10;
  localparam logic [REG_AW-1:0] OFF_STAT   = 6'h14;
  localparam logic [REG_AW-1:0] OFF_FLAGS  = 6'h18;
  localparam logic [REG_AW-1:0] OFF_IRQEN  = 6'h1C;
  localparam logic [REG_AW-1:0] OFF_CLEAR  = 6'h20;

  localparam int BIT_PIPE_EN = 31;
  localparam int BIT_CAP_REQ = 3;
  localparam int BIT_ACTIVE  = 23;
  localparam int BIT_LIM_EN  = 31;

  // event indices inside the flag vector
  localparam int EV_N     = 3;
  localparam int EV_FRAME = 0;
  localparam int EV_SOF   = 1;
  localparam int EV_OVR   = 2;

  // register bit position of each event
  function automatic int ev_bit(input int idx);
    case (idx)
      EV_FRAME: ev_bit = 9;
      EV_SOF:   ev_bit = 10;
      default:  ev_bit = 15;
    endcase
  endfunction
endpackage

// File: rtl/cfc_regbank.sv
module cfc_regbank
  import cfc_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int LIMIT_W = 24,
  parameter int CNT_W   = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_we,
  input  logic [REG_AW-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [EV_N-1:0]     flags,
  input  logic                cap_active,
  input  logic [CNT_W-1:0]    last_cnt,
  output logic                pipe_en,
  output logic                cap_req,
  output logic [ADDR_W-1:0]   shadow_addr,
  output logic                lim_en,
  output logic [LIMIT_W-1:0]  lim_words,
  output logic [EV_N-1:0]     irq_en,
  output logic [EV_N-1:0]     clr_mask
);
  logic wr_pipe, wr_ctrl, wr_base, wr_lim, wr_ien, wr_clr;

  assign wr_pipe = bus_we && (bus_addr == OFF_PIPE);
  assign wr_ctrl = bus_we && (bus_addr == OFF_CTRL);
  assign wr_base = bus_we && (bus_addr == OFF_BASE);
  assign wr_lim  = bus_we && (bus_addr == OFF_LIMIT);
  assign wr_ien  = bus_we && (bus_addr == OFF_IRQEN);
  assign wr_clr  = bus_we && (bus_addr == OFF_CLEAR);

  logic [EV_N-1:0] ien_nxt;
  always_comb begin
    for (int i = 0; i < EV_N; i++) begin
      ien_nxt[i]  = bus_wdata[ev_bit(i)];
      clr_mask[i] = wr_clr & bus_wdata[ev_bit(i)];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pipe_en     <= 1'b0;
      cap_req     <= 1'b0;
      shadow_addr <= '0;
      lim_en      <= 1'b0;
      lim_words   <= '0;
      irq_en      <= '0;
    end else begin
      if (wr_pipe) pipe_en     <= bus_wdata[BIT_PIPE_EN];
      if (wr_ctrl) cap_req     <= bus_wdata[BIT_CAP_REQ];
      if (wr_base) shadow_addr <= bus_wdata[ADDR_W-1:0];
      if (wr_lim) begin
        lim_en    <= bus_wdata[BIT_LIM_EN];
        lim_words <= bus_wdata[LIMIT_W-1:0];
      end
      if (wr_ien) irq_en <= ien_nxt;
    end
  end

  logic [31:0] flag_word, ien_word;
  always_comb begin
    flag_word = '0;
    ien_word  = '0;
    for (int i = 0; i < EV_N; i++) begin
      flag_word[ev_bit(i)] = flags[i];
      ien_word[ev_bit(i)]  = irq_en[i];
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFF_PIPE:  bus_rdata[BIT_PIPE_EN] = pipe_en;
      OFF_CTRL:  bus_rdata[BIT_CAP_REQ] = cap_req;
      OFF_BASE:  bus_rdata = 32'(shadow_addr);
      OFF_LIMIT: begin
        bus_rdata[BIT_LIM_EN]    = lim_en;
        bus_rdata[LIMIT_W-1:0]   = lim_words;
      end
      OFF_COUNT: bus_rdata = 32'(last_cnt);
      OFF_STAT:  bus_rdata[BIT_ACTIVE] = cap_active;
      OFF_FLAGS: bus_rdata = flag_word;
      OFF_IRQEN: bus_rdata = ien_word;
      default:   bus_rdata = '0;
    endcase
  end

  // R2: the shadow only moves on a bus write to its offset
  p_shadow_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_base |=> $stable(shadow_addr));
endmodule

// File: rtl/cfc_event_flags.sv
module cfc_event_flags
  import cfc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [EV_N-1:0] ev_set,
  input  logic [EV_N-1:0] clr_mask,
  input  logic [EV_N-1:0] irq_en,
  output logic [EV_N-1:0] flags,
  output logic            irq
);
  for (genvar g = 0; g < EV_N; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)            flags[g] <= 1'b0;
      else if (ev_set[g])    flags[g] <= 1'b1;
      else if (clr_mask[g])  flags[g] <= 1'b0;
    end

    // R10: a set in the same cycle as a clear leaves the flag high
    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ev_set[g] |=> flags[g]);
    // R10: a clear without a set drops the flag
    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_mask[g] && !ev_set[g]) |=> !flags[g]);
  end

  assign irq = |(flags & irq_en);
endmodule

// File: rtl/cfc_frame_engine.sv
module cfc_frame_engine #(
  parameter int ADDR_W     = 32,
  parameter int LIMIT_W    = 24,
  parameter int CNT_W      = 32,
  parameter int BEAT_BYTES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frm_start,
  input  logic               frm_end,
  input  logic               pix_beat,
  input  logic               wr_ready,
  input  logic               pipe_en,
  input  logic               cap_req,
  input  logic [ADDR_W-1:0]  shadow_addr,
  input  logic               lim_en,
  input  logic [LIMIT_W-1:0] lim_words,
  output logic               wr_valid,
  output logic [ADDR_W-1:0]  wr_addr,
  output logic [CNT_W-1:0]   cnt,
  output logic [CNT_W-1:0]   last_cnt,
  output logic               capturing,
  output logic               frame_evt,
  output logic               ovr_evt
);
  localparam logic [CNT_W-1:0] BEAT = CNT_W'(BEAT_BYTES);

  logic [ADDR_W-1:0] base;
  logic [CNT_W-1:0]  lim_bytes, cnt_nxt;
  logic              over, accepted, clipped;

  assign lim_bytes = CNT_W'({lim_words, 2'b00});
  assign over      = lim_en && ((cnt + BEAT) > lim_bytes);
  assign wr_valid  = capturing && pix_beat && !over;
  assign accepted  = wr_valid && wr_ready;
  assign clipped   = capturing && pix_beat && over;
  assign ovr_evt   = wr_valid && !wr_ready;
  assign frame_evt = capturing && frm_end;
  assign wr_addr   = base + ADDR_W'(cnt);

  always_comb begin
    cnt_nxt = cnt;
    if (accepted)     cnt_nxt = cnt + BEAT;
    else if (clipped) cnt_nxt = lim_bytes;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base      <= '0;
      cnt       <= '0;
      last_cnt  <= '0;
      capturing <= 1'b0;
    end else begin
      if (frame_evt) last_cnt <= cnt_nxt;
      if (frm_start) begin
        base      <= shadow_addr;
        cnt       <= '0;
        capturing <= pipe_en && cap_req;
      end else begin
        cnt <= cnt_nxt;
        if (frame_evt) capturing <= 1'b0;
      end
    end
  end

  // R2: the frame base changes only at a start-of-frame pulse
  p_base_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_start |=> $stable(base));
  // R4: an accepted beat advances the frame count by one beat
  p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accepted && !frm_start) |=> (cnt == $past(cnt) + BEAT));
  // R6: a clipped beat leaves the count at the budget
  p_saturate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clipped && !frm_start) |=> (cnt == $past(lim_bytes)));
  // R5: capture ends only at a frame end or a frame start
  p_stop_at_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(capturing) |-> $past(frm_end || frm_start));
endmodule

// File: rtl/cam_frame_capture.sv
module cam_frame_capture
  import cfc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LIMIT_W    = 24,
  parameter int CNT_W      = 32,
  parameter int BEAT_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              frm_start,
  input  logic              frm_end,
  input  logic              pix_beat,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [31:0]       wr_addr,
  output logic [31:0]       frame_bytes,
  output logic              irq
);
  logic               pipe_en, cap_req, lim_en, capturing, frame_evt, ovr_evt;
  logic [ADDR_W-1:0]  shadow_addr, addr_int;
  logic [LIMIT_W-1:0] lim_words;
  logic [CNT_W-1:0]   cnt, last_cnt;
  logic [EV_N-1:0]    flags, irq_en, clr_mask, ev_set;

  cfc_regbank #(.ADDR_W(ADDR_W), .LIMIT_W(LIMIT_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .flags(flags),
    .cap_active(capturing), .last_cnt(last_cnt), .pipe_en(pipe_en),
    .cap_req(cap_req), .shadow_addr(shadow_addr), .lim_en(lim_en),
    .lim_words(lim_words), .irq_en(irq_en), .clr_mask(clr_mask));

  cfc_frame_engine #(.ADDR_W(ADDR_W), .LIMIT_W(LIMIT_W), .CNT_W(CNT_W),
                     .BEAT_BYTES(BEAT_BYTES)) u_eng (
    .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .frm_end(frm_end),
    .pix_beat(pix_beat), .wr_ready(wr_ready), .pipe_en(pipe_en),
    .cap_req(cap_req), .shadow_addr(shadow_addr), .lim_en(lim_en),
    .lim_words(lim_words), .wr_valid(wr_valid), .wr_addr(addr_int),
    .cnt(cnt), .last_cnt(last_cnt), .capturing(capturing),
    .frame_evt(frame_evt), .ovr_evt(ovr_evt));

  always_comb begin
    ev_set           = '0;
    ev_set[EV_FRAME] = frame_evt;
    ev_set[EV_SOF]   = frm_start;
    ev_set[EV_OVR]   = ovr_evt;
  end

  cfc_event_flags u_flags (
    .clk(clk), .rst_n(rst_n), .ev_set(ev_set), .clr_mask(clr_mask),
    .irq_en(irq_en), .flags(flags), .irq(irq));

  assign wr_addr     = 32'(addr_int);
  assign frame_bytes = 32'(cnt);

  // R9: a refused beat leaves the overrun flag set
  p_overrun_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> flags[EV_OVR]);
  // R9: a refused beat does not move the write address
  p_overrun_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready && !frm_start) |=> $stable(wr_addr));
  // R8: each start-of-frame pulse leaves its flag set
  p_sof_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frm_start |=> flags[EV_SOF]);
  // R3: no write request outside a captured frame
  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_en && frm_start) |=> !wr_valid);
endmodule

// File: tb/sim_cam_frame_capture.sv
module sim_cam_frame_capture;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        frm_start = 1'b0, frm_end = 1'b0, pix_beat = 1'b0;
  logic        wr_valid, wr_ready = 1'b1, irq;
  logic [31:0] wr_addr, frame_bytes;

  int checks = 0, fails = 0, sb_checks = 0, sb_fails = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];

  always #10 clk = ~clk;

  cam_frame_capture u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .frm_start(frm_start),
    .frm_end(frm_end), .pix_beat(pix_beat), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .frame_bytes(frame_bytes),
    .irq(irq));

  // scoreboard monitor: every accepted beat must match the next expected address (R4)
  always @(posedge clk) begin
    if (rst_n && wr_valid && wr_ready) begin
      sb_checks++;
      if (exp_q.size() == 0) begin
        sb_fails++;
        $display("FAIL R4 unexpected write actual=%h expected=none", wr_addr);
      end else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        if (wr_addr !== e) begin
          sb_fails++;
          $display("FAIL R4 write address actual=%h expected=%h", wr_addr, e);
        end
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic sof();
    @(negedge clk); frm_start = 1'b1;
    @(negedge clk); frm_start = 1'b0;
  endtask

  task automatic eof();
    @(negedge clk); frm_end = 1'b1;
    @(negedge clk); frm_end = 1'b0;
  endtask

  // one beat; pushes an expected address when a write should result
  task automatic beat(input bit expect_wr, input logic [31:0] a, output logic seen_valid);
    @(negedge clk);
    if (expect_wr) exp_q.push_back(a);
    pix_beat = 1'b1;
    #1 seen_valid = wr_valid;
    @(negedge clk); pix_beat = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1'b1;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks + sb_checks + 1,
               fails + sb_fails + 1);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int i = 0; i < 9; i++) begin
      rd(6'(i * 4), d);
      check("R1 reg reset", d, 32'h0);
    end
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 wr_valid", {31'b0, wr_valid}, 32'h0);
    check("R1 wr_addr", wr_addr, 32'h0);

    wr(6'h00, 32'h8000_0000);
    wr(6'h04, 32'h0000_0008);
    wr(6'h08, 32'h0000_1000);
    wr(6'h1C, 32'h0000_8600);
    check("R2 base waits for frame start", wr_addr, 32'h0);

    sof();
    rd(6'h18, d); check("R8 sof flag", d, 32'h0000_0400);
    check("R11 irq on sof", {31'b0, irq}, 32'h1);
    check("R2 base loaded at frame start", wr_addr, 32'h0000_1000);
    rd(6'h14, d); check("R3 capture active", d, 32'h0080_0000);

    beat(1, 32'h1000, v); beat(1, 32'h1004, v); beat(1, 32'h1008, v);
    eof();
    rd(6'h10, d); check("R7 byte count", d, 32'd12);
    rd(6'h18, d); check("R7 frame flag", d & 32'h200, 32'h200);

    wr(6'h20, 32'h0000_8600);
    rd(6'h18, d); check("R10 clear all", d, 32'h0);
    check("R11 irq low", {31'b0, irq}, 32'h0);

    // R2 shadow write during a frame only takes effect at the next frame
    sof();
    beat(1, 32'h1000, v);
    wr(6'h08, 32'h0000_2000);
    beat(1, 32'h1004, v);
    eof();
    sof();
    beat(1, 32'h2000, v);

    // R9 overrun
    @(negedge clk); wr_ready = 1'b0;
    beat(0, 32'h0, v);
    check("R9 refused beat still offered", {31'b0, v}, 32'h1);
    @(negedge clk); wr_ready = 1'b1;
    rd(6'h18, d); check("R9 overrun flag", d & 32'h8000, 32'h8000);
    beat(1, 32'h2004, v);
    eof();
    rd(6'h10, d); check("R9 dropped beat not counted", d, 32'd8);

    // R10 set wins over clear
    wr(6'h20, 32'h0000_8600);
    @(negedge clk); bus_we = 1'b1; bus_addr = 6'h20; bus_wdata = 32'h400; frm_start = 1'b1;
    @(negedge clk); bus_we = 1'b0; frm_start = 1'b0;
    rd(6'h18, d); check("R10 set wins", d & 32'h400, 32'h400);

    // R6 limit: 2 words = 8 bytes
    wr(6'h0C, 32'h8000_0002);
    beat(1, 32'h2000, v); beat(1, 32'h2004, v);
    beat(0, 32'h0, v);
    check("R6 beat past budget suppressed", {31'b0, v}, 32'h0);
    check("R6 count saturates", frame_bytes, 32'd8);
    eof();
    rd(6'h10, d); check("R6 stored count", d, 32'd8);

    // R5 graceful stop
    sof();
    wr(6'h0C, 32'h0);
    beat(1, 32'h2000, v);
    wr(6'h04, 32'h0);
    rd(6'h14, d); check("R5 still active after request cleared", d, 32'h0080_0000);
    beat(1, 32'h2004, v);
    eof();
    rd(6'h14, d); check("R5 inactive after frame end", d, 32'h0);
    sof();
    beat(0, 32'h0, v);
    check("R3 no write without request", {31'b0, v}, 32'h0);

    // R12 frame end while idle
    wr(6'h20, 32'h0000_8600);
    eof();
    rd(6'h18, d); check("R12 no frame flag when idle", d & 32'h200, 32'h0);
    rd(6'h10, d); check("R12 count unchanged", d, 32'd8);

    // R3 pipe disabled
    wr(6'h04, 32'h8);
    wr(6'h00, 32'h0);
    sof();
    beat(0, 32'h0, v);
    check("R3 no write with pipe disabled", {31'b0, v}, 32'h0);
    rd(6'h14, d); check("R3 not active with pipe disabled", d, 32'h0);

    repeat (2) @(negedge clk);
    check("R4 scoreboard drained", 32'(exp_q.size()), 32'h0);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks + sb_checks, fails + sb_fails);
      $finish;
    end
  end
endmodule